// File: doc/BRIEF.md
# Wrapping/Incrementing Burst Address Generator

This block sits on the target side of a memory-mapped bus and turns a burst command into a sequence of byte addresses, one for each data beat. A command has three parts: a start address, a beat count and a mode bit. The mode bit selects either an incrementing walk or a wrapping walk. In a wrapping walk the address stays inside an aligned window of `count * WORD_BYTES` bytes. When it reaches the top of that window it continues from the window's base, so only the low-order bits change.

The requester presents one beat at a time by raising `beat_valid`. A beat is accepted on every clock edge where `beat_valid` is high. While no burst is in progress, the accepted beat is the first beat of a new burst, and its command fields are taken from the command inputs. The block drives the address of the beat being presented. It also drives a flag that marks the final beat and a flag that shows a burst is under way.

The `HOLD_CMD` parameter selects one of two capture policies. When it is 0 (the default), the command is registered on the first beat and the command inputs are ignored for the rest of the burst. When it is 1, the requester must keep the command steady for every beat, and the block reads it live instead of storing it.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `burst_active` is low.
- R2: While `burst_active` is low, `beat_addr` equals `cmd_addr`. A beat accepted in that state starts a new burst. A new command is taken only while no burst is active.
- R3: With `cmd_wrap` = 0, beat k of a burst has address start + k*WORD_BYTES (modulo 2^ADDR_W).
- R4: With `cmd_wrap` = 1, beat k has address (start & ~M) | ((start + k*WORD_BYTES) & M), where M = count*WORD_BYTES - 1 and count is a power of two. Example: start 0xC, count 8, 4-byte words gives 0xC, 0x10, 0x14, 0x18, 0x1C, 0x0, 0x4, 0x8.
- R5: `beat_last` is high exactly on the final beat of the burst, when one beat remains. `burst_active` is high after every accepted beat except the final one, and low after the final one.
- R6: A count of 1 is a single-beat burst, and a count of 0 is treated as 1. In both cases `beat_last` is high on the first beat and `burst_active` never rises.
- R7: With HOLD_CMD = 0, values on `cmd_addr`, `cmd_count` and `cmd_wrap` after the first beat have no effect on the address sequence or on the last-beat flag.
- R8: With HOLD_CMD = 1 and the command held steady for the whole burst, the beat addresses and flags are the same as with HOLD_CMD = 0.
- R9: While `beat_valid` is low during a burst, `beat_addr` and `burst_active` do not change, and the burst resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| beat_valid | input | 1 | A beat is presented and accepted at this edge |
| cmd_addr | input | ADDR_W | Burst start byte address |
| cmd_count | input | CNT_W | Beats in the burst (0 means 1) |
| cmd_wrap | input | 1 | 1 = wrapping walk, 0 = incrementing walk |
| beat_addr | output | ADDR_W | Byte address of the presented beat |
| beat_last | output | 1 | Presented beat is the final one |
| burst_active | output | 1 | A burst is in progress beyond its first beat |

## Verification
The assertions check the following on every cycle:
- the idle pass-through of the command address;
- the one-word step between consecutive incrementing beats;
- that every wrapping beat stays inside the aligned window of the captured start;
- that `burst_active` follows `beat_last`;
- that the address is frozen during stalls;
- with the hold policy, that the command stays steady.

Only the bench scenarios can show the exact order of wrapped addresses, such as the return to the window base after the top word. They also show that changing command fields mid-burst has no effect under the first-beat policy, and that single-beat and zero-count bursts end at once.

// File: rtl/bag_pkg.sv
package bag_pkg;
    typedef enum logic {
        WALK_INCR = 1'b0,
        WALK_WRAP = 1'b1
    } walk_e;
endpackage

// File: rtl/bag_span_mask.sv
// Effective beat count and the wrap-window mask derived from it.
module bag_span_mask #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int WB_LG  = 2
) (
    input  logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  eff_count,
    output logic [ADDR_W-1:0] mask
);
    always_comb begin
        eff_count = (count == '0) ? CNT_W'(1) : count;
        mask      = (ADDR_W'(eff_count) << WB_LG) - ADDR_W'(1);
    end
endmodule

// File: rtl/bag_step.sv
// Offsets a base address, either freely or confined to the mask window.
module bag_step #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] offset,
    input  logic [ADDR_W-1:0] mask,
    input  logic              wrap,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] sum;
    always_comb begin
        sum  = base + offset;
        addr = wrap ? ((base & ~mask) | (sum & mask)) : sum;
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 8,
    parameter int WORD_BYTES = 4,
    parameter bit HOLD_CMD   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic              cmd_wrap,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              beat_last,
    output logic              burst_active
);
    localparam int WB_LG = $clog2(WORD_BYTES);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  left;
        logic [ADDR_W-1:0] off;
    } core_t;

    core_t st_d, st_q;

    logic [CNT_W-1:0]  cnt_eff;
    logic [ADDR_W-1:0] cmd_mask;
    logic [ADDR_W-1:0] src_base;
    logic [ADDR_W-1:0] src_mask;
    logic              src_wrap;
    logic [ADDR_W-1:0] walk_addr;

    bag_span_mask #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WB_LG(WB_LG)) u_span (
        .count     (cmd_count),
        .eff_count (cnt_eff),
        .mask      (cmd_mask)
    );

    // Capture policy: first-beat registers, or live command inputs.
    if (HOLD_CMD) begin : g_live
        always_comb begin
            src_base = cmd_addr;
            src_mask = cmd_mask;
            src_wrap = cmd_wrap;
        end
    end else begin : g_capture
        typedef struct packed {
            logic [ADDR_W-1:0] start;
            logic [ADDR_W-1:0] mask;
            walk_e             mode;
        } cap_t;

        cap_t cap_d, cap_q;

        always_comb begin
            cap_d = cap_q;
            if (beat_valid && !st_q.active) begin
                cap_d.start = cmd_addr;
                cap_d.mask  = cmd_mask;
                cap_d.mode  = cmd_wrap ? WALK_WRAP : WALK_INCR;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cap_q <= '{start: '0, mask: '0, mode: WALK_INCR};
            end else begin
                cap_q <= cap_d;
            end
        end

        always_comb begin
            src_base = cap_q.start;
            src_mask = cap_q.mask;
            src_wrap = (cap_q.mode == WALK_WRAP);
        end
    end

    bag_step #(.ADDR_W(ADDR_W)) u_walk (
        .base   (src_base),
        .offset (st_q.off),
        .mask   (src_mask),
        .wrap   (src_wrap),
        .addr   (walk_addr)
    );

    always_comb begin
        st_d = st_q;
        if (beat_valid) begin
            if (!st_q.active) begin
                st_d.left   = cnt_eff - CNT_W'(1);
                st_d.off    = STEP;
                st_d.active = (cnt_eff != CNT_W'(1));
            end else begin
                st_d.left   = st_q.left - CNT_W'(1);
                st_d.off    = st_q.off + STEP;
                st_d.active = (st_q.left != CNT_W'(1));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, left: '0, off: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign beat_addr    = st_q.active ? walk_addr : cmd_addr;
    assign beat_last    = st_q.active ? (st_q.left == CNT_W'(1)) : (cnt_eff == CNT_W'(1));
    assign burst_active = st_q.active;
endmodule

// File: rtl/bag_chk.sv
module bag_chk #(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 8,
    parameter int WORD_BYTES = 4,
    parameter bit HOLD_CMD   = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              beat_valid,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [CNT_W-1:0]  cmd_count,
    input logic              cmd_wrap,
    input logic [ADDR_W-1:0] beat_addr,
    input logic              beat_last,
    input logic              burst_active
);
    logic [ADDR_W-1:0] c_start, c_mask, live_mask;
    logic [CNT_W-1:0]  c_count, live_cnt;
    logic              c_wrap;

    always_comb begin
        live_cnt  = (cmd_count == '0) ? CNT_W'(1) : cmd_count;
        live_mask = ADDR_W'(live_cnt) * ADDR_W'(WORD_BYTES) - ADDR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_start <= '0;
            c_mask  <= '0;
            c_count <= '0;
            c_wrap  <= 1'b0;
        end else if (beat_valid && !burst_active) begin
            c_start <= cmd_addr;
            c_mask  <= live_mask;
            c_count <= cmd_count;
            c_wrap  <= cmd_wrap;
        end
    end

    p_idle_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_active |-> beat_addr == cmd_addr);

    p_incr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && !c_wrap && $past(beat_valid))
            |-> beat_addr == $past(beat_addr) + ADDR_W'(WORD_BYTES));

    p_wrap_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && c_wrap) |-> (beat_addr & ~c_mask) == (c_start & ~c_mask));

    p_last_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_last) |=> !burst_active);

    p_more_beats_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_last) |=> burst_active);

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat_valid && burst_active) |=> (burst_active && $stable(beat_addr)));

    p_cmd_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (HOLD_CMD && burst_active)
            |-> (cmd_addr == c_start && cmd_count == c_count && cmd_wrap == c_wrap));
endmodule

bind burst_addr_gen bag_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES), .HOLD_CMD(HOLD_CMD)
) u_chk (
    .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .cmd_addr(cmd_addr),
    .cmd_count(cmd_count), .cmd_wrap(cmd_wrap), .beat_addr(beat_addr),
    .beat_last(beat_last), .burst_active(burst_active)
);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int CW = 8;
    localparam int WB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic          v_s, v_h;
    logic [AW-1:0] a_s, a_h;
    logic [CW-1:0] c_s, c_h;
    logic          w_s, w_h;
    logic [AW-1:0] ba_s, ba_h;
    logic          bl_s, bl_h, act_s, act_h;
    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW), .CNT_W(CW), .WORD_BYTES(WB), .HOLD_CMD(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .beat_valid(v_s), .cmd_addr(a_s), .cmd_count(c_s),
        .cmd_wrap(w_s), .beat_addr(ba_s), .beat_last(bl_s), .burst_active(act_s));

    burst_addr_gen #(.ADDR_W(AW), .CNT_W(CW), .WORD_BYTES(WB), .HOLD_CMD(1'b1)) dut_hold (
        .clk(clk), .rst_n(rst_n), .beat_valid(v_h), .cmd_addr(a_h), .cmd_count(c_h),
        .cmd_wrap(w_h), .beat_addr(ba_h), .beat_last(bl_h), .burst_active(act_h));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] model(input logic [AW-1:0] s, input logic [CW-1:0] c,
                                             input logic w, input int k);
        int n = (c == 0) ? 1 : int'(c);
        logic [AW-1:0] m = AW'(n * WB - 1);
        logic [AW-1:0] lin = s + AW'(k * WB);
        return w ? ((s & ~m) | (lin & m)) : lin;
    endfunction

    // Runs one burst on both instances; the first-beat instance may see
    // altered command fields after beat 0, the hold instance never does.
    task automatic run_burst(input string req, input logic [AW-1:0] s, input logic [CW-1:0] c,
                             input logic w, input bit scramble, input int gap_at);
        int n = (c == 0) ? 1 : int'(c);
        a_h = s; c_h = c; w_h = w;
        for (int k = 0; k < n; k++) begin
            if (k > 0 && scramble) begin
                a_s = s ^ 16'h5A50; c_s = c + 8'd3; w_s = ~w;
            end else begin
                a_s = s; c_s = c; w_s = w;
            end
            if (k == gap_at && k > 0) begin
                v_s = 1'b0; v_h = 1'b0;
                @(posedge clk); @(negedge clk); #1;
                check({req, " R9 stall addr"}, 32'(ba_s), 32'(model(s, c, w, k)));
                check({req, " R9 stall active"}, 32'(act_s), 32'd1);
                check({req, " R9 stall addr hold"}, 32'(ba_h), 32'(model(s, c, w, k)));
            end
            v_s = 1'b1; v_h = 1'b1;
            #1;
            check({req, " addr"}, 32'(ba_s), 32'(model(s, c, w, k)));
            check({req, " R5 last"}, 32'(bl_s), 32'(k == n - 1));
            check({req, " R5 active"}, 32'(act_s), 32'(k != 0));
            check({req, " R8 addr hold"}, 32'(ba_h), 32'(model(s, c, w, k)));
            check({req, " R8 last hold"}, 32'(bl_h), 32'(k == n - 1));
            @(posedge clk); @(negedge clk);
        end
        v_s = 1'b0; v_h = 1'b0; a_s = s; c_s = c; w_s = w;
        #1;
        check({req, " R5 done"}, 32'(act_s), 32'd0);
        check({req, " R8 done hold"}, 32'(act_h), 32'd0);
    endtask

    task automatic test_reset;
        v_s = 0; v_h = 0; a_s = 16'h0040; a_h = 16'h0040; c_s = 4; c_h = 4; w_s = 0; w_h = 0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        check("R1 active after reset", 32'(act_s), 32'd0);
        check("R1 active after reset hold", 32'(act_h), 32'd0);
        check("R2 idle passthru", 32'(ba_s), 32'h0040);
    endtask

    task automatic test_example_wrap;
        // R4: explicit sequence for start 0xC, 8 beats, 4-byte words
        logic [AW-1:0] seq [8] = '{16'hC, 16'h10, 16'h14, 16'h18, 16'h1C, 16'h0, 16'h4, 16'h8};
        for (int k = 0; k < 8; k++) check("R4 model vs literal", 32'(model(16'hC, 8, 1'b1, k)), 32'(seq[k]));
        run_burst("R4 wrap example", 16'h000C, 8'd8, 1'b1, 1'b0, -1);
    endtask

    task automatic test_incr;   run_burst("R3 incr", 16'h0100, 8'd5, 1'b0, 1'b0, -1); endtask
    task automatic test_wrap4;  run_burst("R4 wrap4", 16'h0038, 8'd4, 1'b1, 1'b0, -1); endtask
    task automatic test_single; run_burst("R6 count1", 16'h0204, 8'd1, 1'b1, 1'b0, -1); endtask
    task automatic test_zero;   run_burst("R6 count0", 16'h0308, 8'd0, 1'b0, 1'b0, -1); endtask
    task automatic test_ignore; run_burst("R7 ignore", 16'h1234, 8'd8, 1'b1, 1'b1, -1); endtask
    task automatic test_ignore_incr; run_burst("R7 ignore incr", 16'hFFF8, 8'd4, 1'b0, 1'b1, -1); endtask
    task automatic test_stall;  run_burst("R9 stall", 16'h0400, 8'd6, 1'b0, 1'b0, 3); endtask
    task automatic test_stall_wrap; run_burst("R9 stall wrap", 16'h0514, 8'd8, 1'b1, 1'b0, 5); endtask

    task automatic test_back_to_back;
        // R2: a new burst starts on the cycle right after a burst ends
        run_burst("R2 first", 16'h0600, 8'd2, 1'b0, 1'b0, -1);
        run_burst("R2 second", 16'h0708, 8'd2, 1'b1, 1'b0, -1);
    endtask

    initial begin
        test_reset;
        test_example_wrap;
        test_incr;
        test_wrap4;
        test_single;
        test_zero;
        test_ignore;
        test_ignore_incr;
        test_stall;
        test_stall_wrap;
        test_back_to_back;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule